// File: doc/BRIEF.md
# SPI Controller Serial Clock and Frame Generator

This block turns a fast input clock into the serial clock, the active-low chip select and the data-out stream of an SPI controller. It also collects data-in into a parallel word. A divisor value `brr` sets the serial period to `brr + 1` input cycles. Values below 3 are clamped to a period of 4. An odd period is split into a longer high phase and a shorter low phase, and the two differ by one input cycle.

The user presents a divisor, a word length and a transmit word, then pulses `start`. The block pulls chip select low and waits one and a half serial periods. It then runs one clock pulse per bit, shifting the word out most significant bit first. It waits half a period after the last falling edge before releasing chip select. At the moment of release, `done` pulses for one cycle and the received word appears on `rx_data`.

Top module: `spi_clkframe_gen`

## Requirements
- R1: The serial period is N = brr + 1 input cycles, and any brr below 3 is treated as N = 4.
- R2: Each serial period is a high phase of ceil(N/2) cycles followed by a low phase of floor(N/2) cycles, so an even N gives equal halves.
- R3: Chip select goes low N + floor(N/2) input cycles before the first rising edge of the serial clock.
- R4: Chip select returns high floor(N/2) input cycles after the last falling edge of the serial clock.
- R5: The frame carries len_m1 + 1 bits (len_m1 from 0 to 15), most significant bit first. Each bit is present on dout when the serial clock rises. dout changes only on a falling serial-clock edge or at the start of a frame.
- R6: din is sampled on each rising serial-clock edge. At the end of the frame, rx_data holds the received bits in its low len_m1 + 1 positions, first bit most significant, with zeros above them.
- R7: The serial clock is low whenever chip select is high.
- R8: busy rises in the cycle after an accepted start, stays high until chip select is released, and always equals the inverse of cs_n.
- R9: done is a single-cycle pulse that coincides with chip select returning high.
- R10: A start during a busy frame is ignored. A change of brr, len_m1 or tx_data during a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brr | input | 7 | Divisor value, period is brr + 1 |
| start | input | 1 | Frame request, accepted when idle |
| len_m1 | input | 4 | Word length minus one |
| tx_data | input | 16 | Transmit word, low len_m1 + 1 bits used |
| din | input | 1 | Serial data from the target |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| dout | output | 1 | Serial data to the target |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_data | output | 16 | Received word |

## Verification
The assertions assume a `start` request is followed by the frame timing defined above. They also assume the divisor never exceeds its seven-bit range, so that a high phase is never longer than 64 cycles. The stimulus drives every input on the falling edge of the input clock. It draws divisors over the whole seven-bit range, including the clamped values, and draws word lengths from 1 to 16. The target model changes din only after a falling serial edge, which keeps the sampled bit stable around each rising edge.

// File: rtl/spi_clkframe_gen.sv
module spi_clkframe_gen #(
  parameter int DIV_W    = 7,
  parameter int WORD_MAX = 16,
  parameter int LEN_W    = $clog2(WORD_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    brr,
  input  logic                start,
  input  logic [LEN_W-1:0]    len_m1,
  input  logic [WORD_MAX-1:0] tx_data,
  input  logic                din,
  output logic                sclk,
  output logic                cs_n,
  output logic                dout,
  output logic                busy,
  output logic                done,
  output logic [WORD_MAX-1:0] rx_data
);
  localparam int CNT_W = DIV_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HI, S_LO, S_LAG} st_t;

  st_t                 st;
  logic [CNT_W-1:0]    cnt, n_r, n_in, hi_r, lo_r;
  logic [LEN_W-1:0]    left;
  logic [WORD_MAX-1:0] sr, rx;

  assign n_in = (brr < DIV_W'(3)) ? CNT_W'(4) : {1'b0, brr} + CNT_W'(1);
  assign hi_r = (n_r + CNT_W'(1)) >> 1;
  assign lo_r = n_r >> 1;
  assign busy = (st != S_IDLE);
  assign cs_n = ~busy;
  assign dout = sr[WORD_MAX-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      n_r     <= CNT_W'(4);
      left    <= '0;
      sr      <= '0;
      rx      <= '0;
      rx_data <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          n_r  <= n_in;
          cnt  <= n_in + (n_in >> 1) - CNT_W'(1);
          sr   <= tx_data << (LEN_W'(WORD_MAX - 1) - len_m1);
          rx   <= '0;
          left <= len_m1;
          st   <= S_LEAD;
        end
        S_LEAD, S_LO: if (cnt == '0) begin
          st   <= S_HI;
          sclk <= 1'b1;
          rx   <= {rx[WORD_MAX-2:0], din};
          cnt  <= hi_r - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        S_HI: if (cnt == '0) begin
          sclk <= 1'b0;
          cnt  <= lo_r - CNT_W'(1);
          if (left == '0) st <= S_LAG;
          else begin
            st   <= S_LO;
            sr   <= sr << 1;
            left <= left - LEN_W'(1);
          end
        end else cnt <= cnt - CNT_W'(1);
        S_LAG: if (cnt == '0) begin
          st      <= S_IDLE;
          done    <= 1'b1;
          rx_data <= rx;
        end else cnt <= cnt - CNT_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_clkframe_gen_chk.sv
module spi_clkframe_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sclk,
  input logic cs_n,
  input logic dout,
  input logic busy,
  input logic done
);
  logic [7:0] hrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hrun <= '0;
    else if (sclk) hrun <= (hrun == 8'hff) ? hrun : hrun + 8'd1;
    else hrun <= '0;
  end

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r5_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(dout));

  a_r9_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  a_r9_release_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  a_r8_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(start) && busy));

  a_r2_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (hrun < 8'd64));
endmodule

bind spi_clkframe_gen spi_clkframe_gen_chk u_chk (.*);

// File: tb/tb_spi_clkframe_gen.sv
module tb_spi_clkframe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  brr = '0;
  logic        start = 1'b0;
  logic [3:0]  len_m1 = '0;
  logic [15:0] tx_data = '0;
  logic        din = 1'b0;
  logic        sclk, cs_n, dout, busy, done;
  logic [15:0] rx_data;

  spi_clkframe_gen dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int e_hi, e_lo, e_lead, e_len;
  logic [15:0] tgt;
  int lowrun, hirun, edges, k, lead_m, lag_m, hi_err, lo_err, done_cnt;
  logic [15:0] mo_word;
  logic p_sclk = 1'b0, p_cs = 1'b1, fdone = 1'b0;

  function automatic int f_n(input logic [6:0] b);
    return (b < 7'd3) ? 4 : int'(b) + 1;
  endfunction
  function automatic logic [15:0] f_mask(input int len);
    return (len >= 16) ? 16'hffff : 16'((32'd1 << len) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (done) done_cnt++;
      if (!cs_n && p_cs) begin
        lowrun = 0; hirun = 0; edges = 0; mo_word = '0; hi_err = 0; lo_err = 0;
        lead_m = -1; lag_m = -1; done_cnt = 0;
        din = tgt[e_len-1]; k = 1;
      end
      if (sclk && !p_sclk) begin
        if (edges == 0) lead_m = lowrun;
        else if (lowrun != e_lo) lo_err++;
        edges++;
        mo_word = {mo_word[14:0], dout};
        hirun = 0;
      end
      if (!sclk && p_sclk) begin
        if (hirun != e_hi) hi_err++;
        lowrun = 0;
        if (k < e_len) din = tgt[e_len-1-k];
        k++;
      end
      if (sclk) hirun++;
      else if (!cs_n) lowrun++;
      if (cs_n && !p_cs) begin
        lag_m = lowrun;
        fdone = 1'b1;
      end
      p_sclk = sclk; p_cs = cs_n;
    end
  end

  task automatic frame(input logic [6:0] b, input int len, input logic [15:0] tx,
                       input logic [15:0] tg, input bit disturb);
    int n = f_n(b);
    int w = 0;
    e_hi = (n + 1) / 2; e_lo = n / 2; e_lead = n + n / 2; e_len = len; tgt = tg;
    fdone = 1'b0;
    @(negedge clk);
    brr = b; len_m1 = 4'(len - 1); tx_data = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && cs_n == 1'b0, "R8 busy after start", int'(busy), 1);
    if (disturb) begin
      repeat (n + 3) @(negedge clk);
      brr = ~b; len_m1 = ~len_m1; tx_data = ~tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!fdone && w < 5000) begin
      @(negedge clk); w++;
    end
    chk(fdone, "R8 frame ends", int'(fdone), 1);
    chk(lead_m == e_lead, "R3 lead", lead_m, e_lead);
    chk(hi_err == 0, "R2 R1 high phase", hi_err, 0);
    chk(lo_err == 0, "R2 R1 low phase", lo_err, 0);
    chk(lag_m == e_lo, "R4 lag", lag_m, e_lo);
    chk(edges == len, "R5 bit count", edges, len);
    chk((mo_word & f_mask(len)) == (tx & f_mask(len)), "R5 dout word",
        int'(mo_word & f_mask(len)), int'(tx & f_mask(len)));
    chk(rx_data == (tg & f_mask(len)), "R6 rx word", int'(rx_data), int'(tg & f_mask(len)));
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    repeat (3) @(negedge clk);
    chk(cs_n && !busy && !sclk, "R10 R7 no restart, idle low", int'(cs_n), 1);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R7 reset cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R7 reset sclk", int'(sclk), 0);
    chk(busy == 1'b0 && done == 1'b0, "R8 reset busy/done", int'(busy), 0);
    rst_n = 1'b1;
    frame(7'd0,   8,  16'h00a5, 16'h003c, 1'b0); // R1 clamp
    frame(7'd2,   1,  16'h0001, 16'h0001, 1'b0); // R1 clamp
    frame(7'd3,   16, 16'h8001, 16'h7ffe, 1'b0); // R2 even min
    frame(7'd4,   5,  16'h0015, 16'h000a, 1'b0); // R2 odd min
    frame(7'd127, 3,  16'h0005, 16'h0002, 1'b0); // R1 max
    frame(7'd6,   16, 16'hbeef, 16'hc0de, 1'b1); // R10 disturb
    frame(7'd9,   12, 16'h0abc, 16'h0123, 1'b1); // R10 disturb
    for (int i = 0; i < 30; i++)
      frame(7'($urandom_range(0, 127)), $urandom_range(1, 16),
            16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule